// File: doc/BRIEF.md
# Interlaced Field Capture Address Controller

This block decides which fields of an interlaced video stream are written to memory and produces the byte address of every captured line. A field starts on a one-cycle field-start strobe. The parity input, sampled in that same cycle, tells the block whether the new field is odd or even. A one-cycle line-start strobe marks each later line. Software sets a two-bit field selection and a single-shot flag. It also loads four line-start base addresses, a line stride, an element size and a ping-pong enable.

The block has four outputs. A capture flag is high for the whole of each field that is being captured. The line address steps by the stride on every line. A three-bit first-pixel byte offset is taken from the low bits of the base. A one-cycle frame-complete pulse fires when a frame has been stored. With ping-pong enabled, whole frames alternate between two pairs of bases. Each pair holds one base for odd fields and one for even fields. The pixel path, the buffering and the bus master downstream use the capture flag and the addresses.

Top module: `vidCapAddr`

## Requirements
- R1: `fenIn` bit 0 enables odd fields and bit 1 enables even fields; value 0 captures nothing. On a field-start strobe, the decision whether the new field is captured appears on `captureActive` in the following cycle and holds until the next field-start strobe.
- R2: With both bits set, capture begins only on an odd field. An even field is captured only when it directly follows a captured odd field in that mode.
- R3: With `oneShotIn` written as 0, every enabled field is captured, field after field, without further writes.
- R4: With `oneShotIn` written as 1, the block captures one field, or one odd-then-even pair when both bits are set. When that capture ends, `fieldEnState` reads 0 and no further field is captured until `fenIn` is written again.
- R5: At the start of a captured field, `lineAddr` loads the selected base with its low three bits cleared. Each line-start strobe inside a captured field adds the stride, modulo 2^ADDR_W. Line-start strobes outside a captured field leave `lineAddr` unchanged.
- R6: `firstOffset` takes bits [2:0] of the selected base at the start of each captured field.
- R7: `compSize` gives the element size as 2^compSize bytes. If the base's low three bits are not a multiple of that size at a captured field start, `firstOffset` is 0 and `offsetErr` goes to 1 and stays there until reset.
- R8: The base index is {buffer, field is even}: 0 = odd/buffer 0, 1 = even/buffer 0, 2 = odd/buffer 1, 3 = even/buffer 1. With `dblBufEn` high, the buffer bit flips on every frame completion, and the field that starts in that same cycle already uses the new buffer. With `dblBufEn` low, the buffer bit is 0.
- R9: Base and stride writes made during a captured field have no effect on that field's addresses. They take effect at the next field start.
- R10: `frameDone` is high for exactly the one cycle after a field-start strobe that ends a frame-completing captured field. A frame-completing field is any captured field in single-parity mode, or the even field in both-field mode.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vsyncStb | input | 1 | One-cycle field-start strobe |
| hsyncStb | input | 1 | One-cycle line-start strobe |
| fieldOdd | input | 1 | Parity of the field that starts with `vsyncStb` (1 = odd) |
| fenWr | input | 1 | Write strobe for `fenIn` and `oneShotIn` |
| fenIn | input | 2 | Field selection: bit 0 odd, bit 1 even |
| oneShotIn | input | 1 | Single-shot capture when 1 |
| baseWr | input | 1 | Write strobe for one base register |
| baseSel | input | 2 | Base register index (see R8) |
| baseData | input | ADDR_W | Base byte address |
| pitchWr | input | 1 | Write strobe for the stride |
| pitchData | input | PITCH_W | Line stride in bytes |
| compSize | input | 2 | Element size, log2 bytes |
| dblBufEn | input | 1 | Ping-pong between the two base pairs |
| captureActive | output | 1 | Current field is being captured |
| lineAddr | output | ADDR_W | Word-aligned byte address of the current line |
| firstOffset | output | 3 | Byte offset of the leftmost element within the 64-bit word |
| frameDone | output | 1 | One-cycle frame completion pulse |
| offsetErr | output | 1 | Sticky misaligned-offset flag |
| fieldEnState | output | 2 | Current field selection |

## Verification
The bench builds the block with ADDR_W = 16 and PITCH_W = 12. At that address width, a base placed near the top of the space wraps within one line step, so the modulo behaviour of the stride adder is exercised directly. The 12-bit stride still leaves room for strides well above one word. The same narrow build keeps every ping-pong, single-shot and parity-ordering sequence to a few dozen cycles, so all field orderings, including an even field arriving first in both-field mode, are covered in one short run.

// File: rtl/vcapPkg.sv
package vcapPkg;

  localparam int NUM_BASES = 4;
  localparam int IDX_W = $clog2(NUM_BASES);

  typedef enum logic [1:0] {
    FSEL_NONE = 2'd0,
    FSEL_ODD  = 2'd1,
    FSEL_EVEN = 2'd2,
    FSEL_BOTH = 2'd3
  } fieldSelT;

  typedef struct packed {
    logic             load;
    logic             step;
    logic [IDX_W-1:0] baseIdx;
  } vcapStrobeT;

  function automatic logic [2:0] sizeMask(input logic [1:0] sz);
    logic [2:0] m;
    case (sz)
      2'd0:    m = 3'b000;
      2'd1:    m = 3'b001;
      2'd2:    m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vcapCtrl.sv
module vcapCtrl
  import vcapPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vsyncStb,
  input  logic       hsyncStb,
  input  logic       fieldOdd,
  input  logic       fenWr,
  input  logic [1:0] fenIn,
  input  logic       oneShotIn,
  input  logic       dblBufEn,
  output vcapStrobeT strb,
  output logic       capActive,
  output logic       frameDone,
  output logic [1:0] fenState
);

  fieldSelT fenR;
  fieldSelT fenAfter;
  logic     oneShotR;
  logic     capR;
  logic     capBothR;
  logic     capOsmR;
  logic     capOddR;
  logic     bufR;
  logic     bufNext;
  logic     doneR;
  logic     frameEnd;
  logic     startCap;
  logic     pairOpen;

  // a captured field completes a frame unless it is the odd half of a pair
  assign frameEnd = vsyncStb && capR && (!capBothR || !capOddR);
  assign pairOpen = capR && capBothR && capOddR;
  assign fenAfter = (frameEnd && capOsmR) ? FSEL_NONE : fenR;
  assign bufNext  = dblBufEn ? (bufR ^ frameEnd) : 1'b0;

  always_comb begin
    case (fenAfter)
      FSEL_ODD:  startCap = fieldOdd;
      FSEL_EVEN: startCap = !fieldOdd;
      FSEL_BOTH: startCap = fieldOdd || pairOpen;
      default:   startCap = 1'b0;
    endcase
  end

  always_comb begin
    strb.load    = vsyncStb && startCap;
    strb.step    = hsyncStb && capR && !vsyncStb;
    strb.baseIdx = {bufNext, !fieldOdd};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fenR     <= FSEL_NONE;
      oneShotR <= 1'b0;
    end else if (fenWr) begin
      fenR     <= fieldSelT'(fenIn);
      oneShotR <= oneShotIn;
    end else if (vsyncStb) begin
      fenR     <= fenAfter;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capR     <= 1'b0;
      capBothR <= 1'b0;
      capOsmR  <= 1'b0;
      capOddR  <= 1'b0;
    end else if (vsyncStb) begin
      capR <= startCap;
      if (startCap) begin
        capBothR <= (fenAfter == FSEL_BOTH);
        capOsmR  <= oneShotR;
        capOddR  <= fieldOdd;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufR  <= 1'b0;
      doneR <= 1'b0;
    end else begin
      bufR  <= bufNext;
      doneR <= frameEnd;
    end
  end

  assign capActive = capR;
  assign frameDone = doneR;
  assign fenState  = fenR;

  AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncStb && fenR == FSEL_NONE) |=> !capR); // R1

  AST_BOTH_STARTS_ODD: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncStb && fenR == FSEL_BOTH && !fieldOdd && !pairOpen) |=> !capR); // R2

  AST_SHOT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && capOsmR && !fenWr) |=> (fenR == FSEL_NONE)); // R4

  AST_DONE_AFTER_VSYNC: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> $past(vsyncStb)); // R10

  AST_BUF_ZERO_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !dblBufEn |=> !bufR); // R8

endmodule

// File: rtl/vcapAddrPath.sv
module vcapAddrPath
  import vcapPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  vcapStrobeT         strb,
  input  logic               baseWr,
  input  logic [IDX_W-1:0]   baseSel,
  input  logic [ADDR_W-1:0]  baseData,
  input  logic               pitchWr,
  input  logic [PITCH_W-1:0] pitchData,
  input  logic [1:0]         compSize,
  output logic [ADDR_W-1:0]  lineAddr,
  output logic [2:0]         firstOffset,
  output logic               offsetErr
);

  localparam int OFS_W = 3;

  logic [NUM_BASES-1:0][ADDR_W-1:0] baseQ;
  logic [PITCH_W-1:0]               pitchReg;
  logic [PITCH_W-1:0]               pitchR;
  logic [ADDR_W-1:0]                lineAddrR;
  logic [OFS_W-1:0]                 offR;
  logic                             errR;
  logic [ADDR_W-1:0]                selBase;
  logic [OFS_W-1:0]                 selOfs;
  logic                             misaligned;

  for (genvar g = 0; g < NUM_BASES; g++) begin : gBase
    logic [ADDR_W-1:0] baseR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseR <= '0;
      end else if (baseWr && baseSel == IDX_W'(g)) begin
        baseR <= baseData;
      end
    end
    assign baseQ[g] = baseR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pitchReg <= '0;
    end else if (pitchWr) begin
      pitchReg <= pitchData;
    end
  end

  assign selBase    = baseQ[strb.baseIdx];
  assign selOfs     = selBase[OFS_W-1:0];
  assign misaligned = (selOfs & sizeMask(compSize)) != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAddrR <= '0;
      pitchR    <= '0;
      offR      <= '0;
    end else if (strb.load) begin
      lineAddrR <= {selBase[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      pitchR    <= pitchReg;
      offR      <= misaligned ? '0 : selOfs;
    end else if (strb.step) begin
      lineAddrR <= lineAddrR + ADDR_W'(pitchR);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errR <= 1'b0;
    end else if (strb.load && misaligned) begin
      errR <= 1'b1;
    end
  end

  assign lineAddr    = lineAddrR;
  assign firstOffset = offR;
  assign offsetErr   = errR;

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(lineAddrR)); // R9

  AST_STRIDE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(pitchR)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errR |=> errR); // R7

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (lineAddrR[OFS_W-1:0] == '0)); // R5

endmodule

// File: rtl/vidCapAddr.sv
module vidCapAddr
  import vcapPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               vsyncStb,
  input  logic               hsyncStb,
  input  logic               fieldOdd,
  input  logic               fenWr,
  input  logic [1:0]         fenIn,
  input  logic               oneShotIn,
  input  logic               baseWr,
  input  logic [1:0]         baseSel,
  input  logic [ADDR_W-1:0]  baseData,
  input  logic               pitchWr,
  input  logic [PITCH_W-1:0] pitchData,
  input  logic [1:0]         compSize,
  input  logic               dblBufEn,
  output logic               captureActive,
  output logic [ADDR_W-1:0]  lineAddr,
  output logic [2:0]         firstOffset,
  output logic               frameDone,
  output logic               offsetErr,
  output logic [1:0]         fieldEnState
);

  vcapStrobeT strb;

  vcapCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .vsyncStb  (vsyncStb),
    .hsyncStb  (hsyncStb),
    .fieldOdd  (fieldOdd),
    .fenWr     (fenWr),
    .fenIn     (fenIn),
    .oneShotIn (oneShotIn),
    .dblBufEn  (dblBufEn),
    .strb      (strb),
    .capActive (captureActive),
    .frameDone (frameDone),
    .fenState  (fieldEnState)
  );

  vcapAddrPath #(
    .ADDR_W  (ADDR_W),
    .PITCH_W (PITCH_W)
  ) i_path (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .baseWr      (baseWr),
    .baseSel     (baseSel),
    .baseData    (baseData),
    .pitchWr     (pitchWr),
    .pitchData   (pitchData),
    .compSize    (compSize),
    .lineAddr    (lineAddr),
    .firstOffset (firstOffset),
    .offsetErr   (offsetErr)
  );

endmodule

// File: tb/test_vidCapAddr.sv
module test_vidCapAddr;

  localparam int AW = 16;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          vsyncStb = 1'b0;
  logic          hsyncStb = 1'b0;
  logic          fieldOdd = 1'b0;
  logic          fenWr = 1'b0;
  logic [1:0]    fenIn = 2'd0;
  logic          oneShotIn = 1'b0;
  logic          baseWr = 1'b0;
  logic [1:0]    baseSel = 2'd0;
  logic [AW-1:0] baseData = '0;
  logic          pitchWr = 1'b0;
  logic [PW-1:0] pitchData = '0;
  logic [1:0]    compSize = 2'd0;
  logic          dblBufEn = 1'b0;
  logic          captureActive;
  logic [AW-1:0] lineAddr;
  logic [2:0]    firstOffset;
  logic          frameDone;
  logic          offsetErr;
  logic [1:0]    fieldEnState;

  always #2 clk = ~clk;

  vidCapAddr #(.ADDR_W(AW), .PITCH_W(PW)) i_vidCapAddr (
    .clk(clk), .rstN(rstN), .vsyncStb(vsyncStb), .hsyncStb(hsyncStb),
    .fieldOdd(fieldOdd), .fenWr(fenWr), .fenIn(fenIn), .oneShotIn(oneShotIn),
    .baseWr(baseWr), .baseSel(baseSel), .baseData(baseData),
    .pitchWr(pitchWr), .pitchData(pitchData), .compSize(compSize),
    .dblBufEn(dblBufEn), .captureActive(captureActive), .lineAddr(lineAddr),
    .firstOffset(firstOffset), .frameDone(frameDone), .offsetErr(offsetErr),
    .fieldEnState(fieldEnState)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  bit modelOn = 0;

  // behavioural reference state
  int mFen, mShotReg, mCap, mPair, mShot, mOdd, mBuf, mDone, mErr;
  int mAddr, mStride, mOff, mStrideReg;
  int mBase[4];

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : refModel
    int ends, fenNow, starts, nb, b, lo;
    if (!rstN) begin
      mFen = 0; mShotReg = 0; mCap = 0; mPair = 0; mShot = 0; mOdd = 0;
      mBuf = 0; mDone = 0; mErr = 0; mAddr = 0; mStride = 0; mOff = 0;
      mStrideReg = 0;
      for (int i = 0; i < 4; i++) mBase[i] = 0;
    end else begin
      ends = (vsyncStb && mCap && (!mPair || !mOdd)) ? 1 : 0;
      fenNow = (ends && mShot) ? 0 : mFen;
      nb = dblBufEn ? (ends ? 1 - mBuf : mBuf) : 0;
      if (vsyncStb) begin
        starts = 0;
        if (fenNow == 1 && fieldOdd) starts = 1;
        if (fenNow == 2 && !fieldOdd) starts = 1;
        if (fenNow == 3 && (fieldOdd || (mCap && mPair && mOdd))) starts = 1;
        if (starts) begin
          b = mBase[nb * 2 + (fieldOdd ? 0 : 1)];
          lo = b % 8;
          mAddr = b - lo;
          mStride = mStrideReg;
          if ((lo % (1 << compSize)) != 0) begin
            mErr = 1;
            mOff = 0;
          end else begin
            mOff = lo;
          end
          mPair = (fenNow == 3) ? 1 : 0;
          mShot = mShotReg;
          mOdd = fieldOdd ? 1 : 0;
        end
        mCap = starts;
        mFen = fenNow;
      end else if (hsyncStb && mCap) begin
        mAddr = (mAddr + mStride) % (1 << AW);
      end
      mBuf = nb;
      mDone = ends;
      if (fenWr) begin
        mFen = fenIn;
        mShotReg = oneShotIn;
      end
      if (baseWr) mBase[baseSel] = baseData;
      if (pitchWr) mStrideReg = pitchData;
    end
  end

  always @(negedge clk) begin
    if (modelOn && !finished) begin
      check("R1", "captureActive vs model", captureActive, mCap);
      check("R5", "lineAddr vs model", lineAddr, mAddr);
      check("R6", "firstOffset vs model", firstOffset, mOff);
      check("R10", "frameDone vs model", frameDone, mDone);
      check("R7", "offsetErr vs model", offsetErr, mErr);
      check("R4", "fieldEnState vs model", fieldEnState, mFen);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic vs(input bit odd);
    @(negedge clk);
    vsyncStb = 1'b1;
    fieldOdd = odd;
    @(negedge clk);
    vsyncStb = 1'b0;
  endtask

  task automatic hs();
    @(negedge clk);
    hsyncStb = 1'b1;
    @(negedge clk);
    hsyncStb = 1'b0;
  endtask

  task automatic setFen(input logic [1:0] f, input bit shot);
    @(negedge clk);
    fenWr = 1'b1;
    fenIn = f;
    oneShotIn = shot;
    @(negedge clk);
    fenWr = 1'b0;
  endtask

  task automatic wrBase(input int idx, input int val);
    @(negedge clk);
    baseWr = 1'b1;
    baseSel = 2'(idx);
    baseData = AW'(val);
    @(negedge clk);
    baseWr = 1'b0;
  endtask

  task automatic wrPitch(input int val);
    @(negedge clk);
    pitchWr = 1'b1;
    pitchData = PW'(val);
    @(negedge clk);
    pitchWr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "captureActive after reset", captureActive, 0);
    check("R11", "lineAddr after reset", lineAddr, 0);
    check("R11", "frameDone after reset", frameDone, 0);
    check("R11", "offsetErr after reset", offsetErr, 0);
    check("R11", "fieldEnState after reset", fieldEnState, 0);
    modelOn = 1;

    wrBase(0, 'h1000);
    wrBase(1, 'h2000);
    wrBase(2, 'h3000);
    wrBase(3, 'h4000);
    wrPitch('h100);

    // R1: nothing captured with selection 0
    vs(1);
    check("R1", "no capture when selection is 0", captureActive, 0);
    hs();
    check("R5", "line strobe outside capture ignored", lineAddr, 0);

    // R1/R3/R5: odd only, continuous
    setFen(2'd1, 1'b0);
    vs(0);
    check("R1", "odd-only skips even field", captureActive, 0);
    vs(1);
    check("R1", "odd-only captures odd field", captureActive, 1);
    check("R5", "field start loads base 0", lineAddr, 'h1000);
    hs(); hs(); hs();
    check("R5", "three strides added", lineAddr, 'h1300);
    vs(0);
    check("R10", "single-parity field completes frame", frameDone, 1);
    check("R1", "even skipped again", captureActive, 0);
    @(negedge clk);
    check("R10", "frame pulse lasts one cycle", frameDone, 0);
    vs(1);
    check("R3", "continuous capture of next odd field", captureActive, 1);

    // even only
    setFen(2'd2, 1'b0);
    vs(1);
    check("R1", "even-only skips odd field", captureActive, 0);
    vs(0);
    check("R1", "even-only captures even field", captureActive, 1);
    check("R8", "even field uses base 1", lineAddr, 'h2000);

    // R2: both fields, even field first is not captured
    setFen(2'd3, 1'b0);
    vs(0);
    check("R2", "both mode does not start on even", captureActive, 0);
    vs(1);
    check("R2", "both mode starts on odd", captureActive, 1);
    hs();
    vs(0);
    check("R10", "odd half does not complete frame", frameDone, 0);
    check("R2", "even following odd captured", captureActive, 1);
    check("R5", "even field loads base 1", lineAddr, 'h2000);
    vs(1);
    check("R10", "even half completes frame", frameDone, 1);

    // R8: ping-pong
    dblBufEn = 1'b1;
    vs(0);
    check("R8", "buffer 0 even base", lineAddr, 'h2000);
    vs(1);
    check("R8", "after frame, odd from buffer 1", lineAddr, 'h3000);
    vs(0);
    check("R8", "even from buffer 1", lineAddr, 'h4000);
    vs(1);
    check("R8", "back to buffer 0 odd", lineAddr, 'h1000);
    vs(0);
    vs(1);
    dblBufEn = 1'b0;
    vs(0);
    check("R8", "disabled ping-pong uses buffer 0", lineAddr, 'h2000);

    // R4: one-shot single odd field
    setFen(2'd0, 1'b0);
    vs(1);
    setFen(2'd1, 1'b1);
    vs(0);
    check("R4", "one-shot waits for odd", captureActive, 0);
    vs(1);
    check("R4", "one-shot captures odd", captureActive, 1);
    vs(1);
    check("R4", "selection cleared after shot", fieldEnState, 0);
    check("R10", "shot frame completes", frameDone, 1);
    check("R4", "no capture after shot", captureActive, 0);
    vs(1);
    check("R4", "still idle after shot", captureActive, 0);

    // R4: one-shot frame pair
    setFen(2'd3, 1'b1);
    vs(1);
    check("R4", "pair shot odd captured", captureActive, 1);
    vs(0);
    check("R4", "pair shot even captured", captureActive, 1);
    check("R4", "selection kept mid-pair", fieldEnState, 3);
    vs(1);
    check("R4", "pair shot clears selection", fieldEnState, 0);
    check("R4", "pair shot ends capture", captureActive, 0);

    // R9: writes mid-field
    setFen(2'd1, 1'b0);
    vs(1);
    check("R9", "field loads old base", lineAddr, 'h1000);
    wrBase(0, 'h5000);
    wrPitch('h40);
    hs();
    check("R9", "old stride kept mid-field", lineAddr, 'h1100);
    vs(0);
    vs(1);
    check("R9", "new base at next field", lineAddr, 'h5000);
    hs();
    check("R9", "new stride at next field", lineAddr, 'h5040);

    // R6/R7: offsets
    compSize = 2'd1;
    wrBase(0, 'h6006);
    vs(0);
    vs(1);
    check("R6", "legal offset passed", firstOffset, 6);
    check("R7", "no error for legal offset", offsetErr, 0);
    check("R5", "word-aligned address", lineAddr, 'h6000);
    compSize = 2'd2;
    vs(0);
    vs(1);
    check("R7", "illegal offset forced to 0", firstOffset, 0);
    check("R7", "error flag set", offsetErr, 1);
    wrBase(0, 'h6004);
    vs(0);
    vs(1);
    check("R6", "aligned offset 4", firstOffset, 4);
    check("R7", "error flag sticky", offsetErr, 1);

    // R5: address wrap
    compSize = 2'd0;
    wrBase(0, 'hFFE0);
    wrPitch('h20);
    vs(0);
    vs(1);
    check("R5", "base near top", lineAddr, 'hFFE0);
    hs();
    check("R5", "address wraps", lineAddr, 'h0000);
    hs();
    check("R5", "after wrap", lineAddr, 'h0020);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule